// File: doc/BRIEF.md
# Transactional Conflict Responder and Arbiter

This block sits beside a processor's private cache in a multiprocessor with hardware transactional memory. While a transaction runs, it keeps a read mark and a write mark for every cache line, a single spill flag that remembers that a marked line left the cache, a transaction timestamp and a flag that warns of a possible wait cycle. Coherence requests forwarded from the directory for this processor are answered with ACK (no conflict), NACK (conflict) or CLEAN (no record here, the directory may drop a stale sticky owner). Loads and stores performed inside a transaction set the marks. Evictions of marked lines set the spill flag, so later forwarded requests for absent lines are still refused.

When this processor's own coherence request is refused, the block decides between two outcomes. One is a retry after a backoff that doubles on every refusal up to a ceiling. The other is an abort trap to the software handler. The trap is taken only when the refuser is logically earlier and this processor has already refused an earlier transaction, since only then can a wait cycle exist. Timestamps are ordered by value, with the lower processor number first on a tie. A timestamp taken at the outermost begin survives an abort, so a restarted transaction keeps its age.

The transaction sequencer has three named states. TX_IDLE goes to TX_ACTIVE on a begin. TX_ACTIVE counts nested begins and commits, goes back to TX_IDLE on the commit that closes the outermost level, and goes to TX_ABORTING on an explicit abort or a trap. TX_ABORTING returns to TX_IDLE when the handler reports that the abort is complete. The refusal arbiter has four named states. ARB_IDLE goes to ARB_WAIT when a refusal is to be retried, or to ARB_TRAP when it is to be trapped. ARB_WAIT counts the backoff down and moves to ARB_RETRY at one. ARB_RETRY and ARB_TRAP each last one cycle and return to ARB_IDLE.

Top module: `txcr_unit`

## Requirements
- R1: Marks are set only in TX_ACTIVE. A load (acc_op 0) sets the read mark only if the line is valid. A store (acc_op 1) sets the write mark only if the line is in modified state. Accesses outside a transaction leave no mark.
- R2: A forwarded request with fwd_valid high gets rsp_valid high on the next cycle. For a line present in the cache, a shared read (fwd_kind 0) conflicts if the write mark is set. An exclusive read (1) or invalidation (2) conflicts if either mark is set. A conflict gives rsp_code 2 (NACK), otherwise 1 (ACK).
- R3: Evicting a line whose read or write mark is set raises ovf_flag. Evicting an unmarked line does not.
- R4: A forwarded request for a line not in the cache gets NACK if a transaction is open (TX_ACTIVE or TX_ABORTING) and ovf_flag is set. Otherwise it gets rsp_code 3 (CLEAN).
- R5: A commit at nesting depth one clears all marks, ovf_flag and pcycle_flag, and drops tx_active. An inner commit changes none of them.
- R6: pcycle_flag is set when this unit answers NACK to a requester that is logically earlier: a lower timestamp, or an equal timestamp with a lower processor number.
- R7: A refusal of this unit's own request, taken in ARB_IDLE, pulses abort_trap for one cycle on the next cycle if the refuser is logically earlier and pcycle_flag is set. The transaction then enters TX_ABORTING. In every other case the request is retried.
- R8: A retried refusal raises retry_req for one cycle, exactly B cycles after the refusal cycle. B starts at 1, doubles on each retried refusal up to BO_MAX, and returns to 1 when a transaction ends.
- R9: A line filled inside a transaction while the directory marks it sticky at this processor (acc_op 2) gets both marks.
- R10: tx_ts is loaded from ts_now at an outermost begin, except after a completed abort: the next begin then keeps the old value, until an outermost commit. Completing an abort clears all marks, ovf_flag and pcycle_flag.
- R11: After reset rsp_valid, rsp_code, retry_req, abort_trap, tx_active, ovf_flag, pcycle_flag and tx_ts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_pid | input | PID_W | Number of this processor, breaks timestamp ties |
| ts_now | input | TS_W | Running time value sampled at an outermost begin |
| tx_begin | input | 1 | Begin instruction (nests) |
| tx_commit | input | 1 | Commit instruction |
| tx_abort | input | 1 | Explicit abort instruction |
| abort_done | input | 1 | Handler has finished undoing the log |
| acc_valid | input | 1 | A cache access completes this cycle |
| acc_op | input | 2 | 0 load, 1 store, 2 fill of a line sticky at this processor |
| acc_idx | input | IDX_W | Cache line of the access |
| acc_blk_valid | input | 1 | Line holds a valid coherence state |
| acc_blk_mod | input | 1 | Line is in modified state |
| evict_valid | input | 1 | A line leaves the cache this cycle |
| evict_idx | input | IDX_W | Cache line being evicted |
| fwd_valid | input | 1 | Forwarded coherence request present |
| fwd_kind | input | 2 | 0 shared read, 1 exclusive read, 2 invalidation |
| fwd_hit | input | 1 | Requested line is present in the cache |
| fwd_idx | input | IDX_W | Cache line of the forwarded request |
| fwd_ts | input | TS_W | Requester's timestamp |
| fwd_pid | input | PID_W | Requester's processor number |
| own_nack | input | 1 | This unit's own request was refused |
| own_nack_ts | input | TS_W | Timestamp of the refusing transaction |
| own_nack_pid | input | PID_W | Processor number of the refuser |
| rsp_valid | output | 1 | Response to forwarded request valid |
| rsp_code | output | 2 | 0 none, 1 ACK, 2 NACK, 3 CLEAN |
| retry_req | output | 1 | Reissue the refused request now |
| abort_trap | output | 1 | Trap to the conflict handler |
| tx_active | output | 1 | A transaction is open |
| ovf_flag | output | 1 | A marked line was evicted in this transaction |
| pcycle_flag | output | 1 | An earlier transaction was refused |
| tx_ts | output | TS_W | Timestamp of the current transaction |

## Verification
The bench targets the asymmetries between request kinds. A design that checked the read mark on a shared read would refuse readers of lines that were only read. A design that ignored the read mark on invalidations would let a writer slip past a reader. Timestamp ties are driven from both sides, because swapping the processor-number tie-break would set the possible-cycle flag against a later requester and could cause a needless abort. The backoff is walked past its ceiling and then checked again after a completed abort: a counter that does not saturate would overflow, and one that is not reset would delay the first retry of the next transaction. A restart after an abort is checked to keep the old timestamp, since reloading it would let a restarted transaction starve behind newer ones.

// File: rtl/txcr_pkg.sv
package txcr_pkg;

    typedef enum logic [1:0] {
        FWD_GETS = 2'd0,
        FWD_GETX = 2'd1,
        FWD_INV  = 2'd2
    } fwd_kind_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_NACK  = 2'd2,
        RSP_CLEAN = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_STICKY = 2'd2
    } acc_op_e;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_ACTIVE   = 2'd1,
        TX_ABORTING = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WAIT  = 2'd1,
        ARB_RETRY = 2'd2,
        ARB_TRAP  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/txcr_order.sv
// Logical age comparison: a is older than b.
module txcr_order #(
    parameter int TS_W  = 16,
    parameter int PID_W = 4
) (
    input  logic [TS_W-1:0]  a_ts,
    input  logic [PID_W-1:0] a_pid,
    input  logic [TS_W-1:0]  b_ts,
    input  logic [PID_W-1:0] b_pid,
    output logic             a_first
);
    always_comb begin
        a_first = (a_ts < b_ts) || ((a_ts == b_ts) && (a_pid < b_pid));
    end
endmodule

// File: rtl/txcr_rwtrack.sv
// Per-line read/write marks and the spill flag.
module txcr_rwtrack
    import txcr_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [1:0]       set_op,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             blk_valid,
    input  logic             blk_mod,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             clear_all,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_r,
    output logic             look_w,
    output logic             ovf
);
    logic [NUM_LINES-1:0] rd_mark;
    logic [NUM_LINES-1:0] wr_mark;
    logic                 set_r_any;
    logic                 set_w_any;
    logic                 evict_marked;

    always_comb begin
        set_r_any = set_en && ((set_op == ACC_LOAD && blk_valid) || set_op == ACC_STICKY);
        set_w_any = set_en && ((set_op == ACC_STORE && blk_mod) || set_op == ACC_STICKY);
        evict_marked = evict_valid && (rd_mark[evict_idx] || wr_mark[evict_idx]);
        look_r = rd_mark[look_idx];
        look_w = wr_mark[look_idx];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit_set;
        logic hit_evict;
        always_comb begin
            hit_set   = (set_idx == IDX_W'(g));
            hit_evict = evict_valid && (evict_idx == IDX_W'(g));
        end
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                rd_mark[g] <= 1'b0;
                wr_mark[g] <= 1'b0;
            end else begin
                rd_mark[g] <= (rd_mark[g] && !hit_evict) || (hit_set && set_r_any);
                wr_mark[g] <= (wr_mark[g] && !hit_evict) || (hit_set && set_w_any);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            ovf <= 1'b0;
        end else if (evict_marked) begin
            ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/txcr_responder.sv
// Answers forwarded requests and keeps the possible-cycle flag.
module txcr_responder
    import txcr_pkg::*;
#(
    parameter int TS_W  = 16,
    parameter int PID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_valid,
    input  logic [1:0]       fwd_kind,
    input  logic             fwd_hit,
    input  logic [TS_W-1:0]  fwd_ts,
    input  logic [PID_W-1:0] fwd_pid,
    input  logic             look_r,
    input  logic             look_w,
    input  logic             tx_open,
    input  logic             ovf,
    input  logic             clear_all,
    input  logic [TS_W-1:0]  own_ts,
    input  logic [PID_W-1:0] own_pid,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic             pcycle
);
    logic      req_first;
    logic      conflict;
    rsp_code_e code_now;

    txcr_order #(.TS_W(TS_W), .PID_W(PID_W)) u_age (
        .a_ts   (fwd_ts),
        .a_pid  (fwd_pid),
        .b_ts   (own_ts),
        .b_pid  (own_pid),
        .a_first(req_first)
    );

    always_comb begin
        if (fwd_kind == FWD_GETS) begin
            conflict = look_w;
        end else begin
            conflict = look_r || look_w;
        end
        if (fwd_hit) begin
            code_now = conflict ? RSP_NACK : RSP_ACK;
        end else begin
            code_now = (tx_open && ovf) ? RSP_NACK : RSP_CLEAN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_NONE;
            pcycle    <= 1'b0;
        end else begin
            rsp_valid <= fwd_valid;
            rsp_code  <= fwd_valid ? code_now : RSP_NONE;
            if (clear_all) begin
                pcycle <= 1'b0;
            end else if (fwd_valid && code_now == RSP_NACK && req_first) begin
                pcycle <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txcr_arbiter.sv
// Decides retry-with-backoff or abort trap for refused own requests.
module txcr_arbiter
    import txcr_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int PID_W  = 4,
    parameter int BO_MAX = 8,
    localparam int BO_W  = $clog2(BO_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_nack,
    input  logic [TS_W-1:0]  nack_ts,
    input  logic [PID_W-1:0] nack_pid,
    input  logic [TS_W-1:0]  own_ts,
    input  logic [PID_W-1:0] own_pid,
    input  logic             pcycle,
    input  logic             clear_all,
    output logic             trap_fire,
    output logic             retry_req,
    output logic             abort_trap
);
    arb_state_e        st_q;
    arb_state_e        st_d;
    logic [BO_W-1:0]   cnt_q;
    logic [BO_W-1:0]   bo_q;
    logic [BO_W:0]     bo_dbl;
    logic              nacker_first;
    logic              take_retry;

    txcr_order #(.TS_W(TS_W), .PID_W(PID_W)) u_age (
        .a_ts   (nack_ts),
        .a_pid  (nack_pid),
        .b_ts   (own_ts),
        .b_pid  (own_pid),
        .a_first(nacker_first)
    );

    always_comb begin
        trap_fire  = (st_q == ARB_IDLE) && own_nack && nacker_first && pcycle;
        take_retry = (st_q == ARB_IDLE) && own_nack && !trap_fire;
        bo_dbl     = {bo_q, 1'b0};
        st_d       = st_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (trap_fire) begin
                    st_d = ARB_TRAP;
                end else if (take_retry) begin
                    st_d = ARB_WAIT;
                end
            end
            ARB_WAIT: begin
                if (cnt_q == BO_W'(1)) begin
                    st_d = ARB_RETRY;
                end
            end
            ARB_RETRY: st_d = ARB_IDLE;
            ARB_TRAP:  st_d = ARB_IDLE;
            default:   st_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ARB_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bo_q  <= BO_W'(1);
        end else begin
            if (take_retry) begin
                cnt_q <= bo_q;
            end else if (st_q == ARB_WAIT) begin
                cnt_q <= cnt_q - BO_W'(1);
            end
            if (clear_all) begin
                bo_q <= BO_W'(1);
            end else if (take_retry) begin
                bo_q <= (bo_dbl > (BO_W + 1)'(BO_MAX)) ? BO_W'(BO_MAX) : bo_dbl[BO_W-1:0];
            end
        end
    end

    always_comb begin
        retry_req  = (st_q == ARB_RETRY);
        abort_trap = (st_q == ARB_TRAP);
    end
endmodule

// File: rtl/txcr_unit.sv
// Top: transaction sequencer plus the three sub-blocks.
module txcr_unit
    import txcr_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TS_W      = 16,
    parameter int PID_W     = 4,
    parameter int DEPTH_W   = 4,
    parameter int BO_MAX    = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PID_W-1:0] my_pid,
    input  logic [TS_W-1:0]  ts_now,
    input  logic             tx_begin,
    input  logic             tx_commit,
    input  logic             tx_abort,
    input  logic             abort_done,
    input  logic             acc_valid,
    input  logic [1:0]       acc_op,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_blk_valid,
    input  logic             acc_blk_mod,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             fwd_valid,
    input  logic [1:0]       fwd_kind,
    input  logic             fwd_hit,
    input  logic [IDX_W-1:0] fwd_idx,
    input  logic [TS_W-1:0]  fwd_ts,
    input  logic [PID_W-1:0] fwd_pid,
    input  logic             own_nack,
    input  logic [TS_W-1:0]  own_nack_ts,
    input  logic [PID_W-1:0] own_nack_pid,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic             retry_req,
    output logic             abort_trap,
    output logic             tx_active,
    output logic             ovf_flag,
    output logic             pcycle_flag,
    output logic [TS_W-1:0]  tx_ts
);
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);
    localparam logic [DEPTH_W-1:0] DEPTH_TOP = {DEPTH_W{1'b1}};

    tx_state_e          txs_q;
    tx_state_e          txs_d;
    logic [DEPTH_W-1:0] depth_q;
    logic               keep_ts_q;
    logic               outer_commit;
    logic               abort_start;
    logic               abort_end;
    logic               clear_all;
    logic               trap_fire;
    logic               look_r;
    logic               look_w;

    always_comb begin
        outer_commit = (txs_q == TX_ACTIVE) && tx_commit && (depth_q == DEPTH_ONE);
        abort_start  = (txs_q == TX_ACTIVE) && (tx_abort || trap_fire);
        abort_end    = (txs_q == TX_ABORTING) && abort_done;
        clear_all    = outer_commit || abort_end;
        txs_d        = txs_q;
        unique case (txs_q)
            TX_IDLE: begin
                if (tx_begin) begin
                    txs_d = TX_ACTIVE;
                end
            end
            TX_ACTIVE: begin
                if (abort_start) begin
                    txs_d = TX_ABORTING;
                end else if (outer_commit) begin
                    txs_d = TX_IDLE;
                end
            end
            TX_ABORTING: begin
                if (abort_done) begin
                    txs_d = TX_IDLE;
                end
            end
            default: txs_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txs_q <= TX_IDLE;
        end else begin
            txs_q <= txs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q   <= '0;
            keep_ts_q <= 1'b0;
            tx_ts     <= '0;
        end else begin
            unique case (txs_q)
                TX_IDLE: begin
                    if (tx_begin) begin
                        depth_q <= DEPTH_ONE;
                        if (!keep_ts_q) begin
                            tx_ts <= ts_now;
                        end
                    end
                end
                TX_ACTIVE: begin
                    if (abort_start) begin
                        depth_q <= depth_q;
                    end else if (tx_begin) begin
                        if (depth_q != DEPTH_TOP) begin
                            depth_q <= depth_q + DEPTH_ONE;
                        end
                    end else if (tx_commit) begin
                        depth_q <= depth_q - DEPTH_ONE;
                        if (outer_commit) begin
                            keep_ts_q <= 1'b0;
                        end
                    end
                end
                TX_ABORTING: begin
                    if (abort_done) begin
                        depth_q   <= '0;
                        keep_ts_q <= 1'b1;
                    end
                end
                default: depth_q <= '0;
            endcase
        end
    end

    always_comb begin
        tx_active = (txs_q != TX_IDLE);
    end

    txcr_rwtrack #(.NUM_LINES(NUM_LINES)) u_marks (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (acc_valid && (txs_q == TX_ACTIVE)),
        .set_op     (acc_op),
        .set_idx    (acc_idx),
        .blk_valid  (acc_blk_valid),
        .blk_mod    (acc_blk_mod),
        .evict_valid(evict_valid),
        .evict_idx  (evict_idx),
        .clear_all  (clear_all),
        .look_idx   (fwd_idx),
        .look_r     (look_r),
        .look_w     (look_w),
        .ovf        (ovf_flag)
    );

    txcr_responder #(.TS_W(TS_W), .PID_W(PID_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwd_valid(fwd_valid),
        .fwd_kind (fwd_kind),
        .fwd_hit  (fwd_hit),
        .fwd_ts   (fwd_ts),
        .fwd_pid  (fwd_pid),
        .look_r   (look_r),
        .look_w   (look_w),
        .tx_open  (tx_active),
        .ovf      (ovf_flag),
        .clear_all(clear_all),
        .own_ts   (tx_ts),
        .own_pid  (my_pid),
        .rsp_valid(rsp_valid),
        .rsp_code (rsp_code),
        .pcycle   (pcycle_flag)
    );

    txcr_arbiter #(.TS_W(TS_W), .PID_W(PID_W), .BO_MAX(BO_MAX)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_nack  (own_nack),
        .nack_ts   (own_nack_ts),
        .nack_pid  (own_nack_pid),
        .own_ts    (tx_ts),
        .own_pid   (my_pid),
        .pcycle    (pcycle_flag),
        .clear_all (clear_all),
        .trap_fire (trap_fire),
        .retry_req (retry_req),
        .abort_trap(abort_trap)
    );
endmodule

// File: rtl/txcr_unit_chk.sv
module txcr_unit_chk
    import txcr_pkg::*;
#(
    parameter int TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fwd_valid,
    input logic            fwd_hit,
    input logic            evict_valid,
    input logic            tx_active,
    input logic            rsp_valid,
    input logic [1:0]      rsp_code,
    input logic            retry_req,
    input logic            abort_trap,
    input logic            ovf_flag,
    input logic            pcycle_flag,
    input logic [TS_W-1:0] tx_ts
);
    assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> rsp_valid);

    assert_ovf_from_evict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(evict_valid));

    assert_idle_miss_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_hit && !tx_active) |=> (rsp_code == RSP_CLEAN));

    assert_end_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> (!ovf_flag && !pcycle_flag));

    assert_pcycle_on_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pcycle_flag) |-> (rsp_code == RSP_NACK));

    assert_trap_xor_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_req && abort_trap));

    assert_retry_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);

    assert_ts_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> (!tx_active || $stable(tx_ts)));
endmodule

bind txcr_unit txcr_unit_chk #(.TS_W(TS_W)) u_chk (.*);

// File: tb/test_txcr_unit.sv
module test_txcr_unit;
    localparam int NL = 8;
    localparam int TSW = 16;
    localparam int PW = 4;
    localparam int BOM = 8;
    localparam int MY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] my_pid = PW'(MY);
    logic [TSW-1:0] ts_now = '0;
    logic tx_begin = 0, tx_commit = 0, tx_abort = 0, abort_done = 0;
    logic acc_valid = 0; logic [1:0] acc_op = 0; logic [2:0] acc_idx = 0;
    logic acc_blk_valid = 0, acc_blk_mod = 0;
    logic evict_valid = 0; logic [2:0] evict_idx = 0;
    logic fwd_valid = 0; logic [1:0] fwd_kind = 0; logic fwd_hit = 0;
    logic [2:0] fwd_idx = 0; logic [TSW-1:0] fwd_ts = 0; logic [PW-1:0] fwd_pid = 0;
    logic own_nack = 0; logic [TSW-1:0] own_nack_ts = 0; logic [PW-1:0] own_nack_pid = 0;
    logic rsp_valid; logic [1:0] rsp_code; logic retry_req, abort_trap;
    logic tx_active, ovf_flag, pcycle_flag; logic [TSW-1:0] tx_ts;

    always #10 clk = ~clk;

    txcr_unit #(.NUM_LINES(NL), .TS_W(TSW), .PID_W(PW), .DEPTH_W(4), .BO_MAX(BOM)) i_txcr_unit (
        .clk(clk), .rst_n(rst_n), .my_pid(my_pid), .ts_now(ts_now),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort), .abort_done(abort_done),
        .acc_valid(acc_valid), .acc_op(acc_op), .acc_idx(acc_idx),
        .acc_blk_valid(acc_blk_valid), .acc_blk_mod(acc_blk_mod),
        .evict_valid(evict_valid), .evict_idx(evict_idx),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_hit(fwd_hit), .fwd_idx(fwd_idx),
        .fwd_ts(fwd_ts), .fwd_pid(fwd_pid),
        .own_nack(own_nack), .own_nack_ts(own_nack_ts), .own_nack_pid(own_nack_pid),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .retry_req(retry_req), .abort_trap(abort_trap),
        .tx_active(tx_active), .ovf_flag(ovf_flag), .pcycle_flag(pcycle_flag), .tx_ts(tx_ts)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_r[NL]; bit m_w[NL];
    bit m_ovf = 0, m_pc = 0, m_keep = 0;
    int m_txs = 0, m_depth = 0, m_ts = 0;
    int m_arb = 0, m_cnt = 0, m_bo = 1;
    bit m_rspv = 0; int m_rspc = 0;

    function automatic bit older(int ats, int apid, int bts, int bpid);
        return (ats < bts) || (ats == bts && apid < bpid);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit act, outer, trap, ab_start, ab_end, clr, conf, ev_mark;
        int code;
        act = (m_txs != 0);
        outer = (m_txs == 1) && tx_commit && (m_depth == 1);
        trap = (m_arb == 0) && own_nack && older(own_nack_ts, own_nack_pid, m_ts, MY) && m_pc;
        ab_start = (m_txs == 1) && (tx_abort || trap);
        ab_end = (m_txs == 2) && abort_done;
        clr = outer || ab_end;
        code = 0;
        if (fwd_valid) begin
            if (fwd_hit) begin
                conf = (fwd_kind == 0) ? m_w[fwd_idx] : (m_r[fwd_idx] | m_w[fwd_idx]);
                code = conf ? 2 : 1;
            end else begin
                code = (act && m_ovf) ? 2 : 3;
            end
        end
        ev_mark = evict_valid && (m_r[evict_idx] | m_w[evict_idx]);
        m_rspv = fwd_valid;
        m_rspc = code;
        if (clr) m_pc = 0;
        else if (code == 2 && older(fwd_ts, fwd_pid, m_ts, MY)) m_pc = 1;
        if (clr) begin
            for (int i = 0; i < NL; i++) begin m_r[i] = 0; m_w[i] = 0; end
            m_ovf = 0;
        end else begin
            if (evict_valid) begin m_r[evict_idx] = 0; m_w[evict_idx] = 0; end
            if (m_txs == 1 && acc_valid) begin
                if ((acc_op == 0 && acc_blk_valid) || acc_op == 2) m_r[acc_idx] = 1;
                if ((acc_op == 1 && acc_blk_mod) || acc_op == 2) m_w[acc_idx] = 1;
            end
            if (ev_mark) m_ovf = 1;
        end
        case (m_arb)
            0: if (own_nack) begin
                if (trap) m_arb = 3;
                else begin
                    m_arb = 1; m_cnt = m_bo;
                    if (!clr) m_bo = (m_bo * 2 > BOM) ? BOM : m_bo * 2;
                end
            end
            1: if (m_cnt == 1) m_arb = 2; else m_cnt--;
            default: m_arb = 0;
        endcase
        if (clr) m_bo = 1;
        case (m_txs)
            0: if (tx_begin) begin
                m_txs = 1; m_depth = 1;
                if (!m_keep) m_ts = ts_now;
            end
            1: if (ab_start) m_txs = 2;
               else if (tx_begin) begin if (m_depth < 15) m_depth++; end
               else if (tx_commit) begin
                   m_depth--;
                   if (m_depth == 0) begin m_txs = 0; m_keep = 0; end
               end
            default: if (abort_done) begin m_txs = 0; m_depth = 0; m_keep = 1; end
        endcase
    endtask

    task automatic compare();
        chk(rsp_valid == m_rspv, "R2 rsp_valid", rsp_valid, m_rspv);
        chk(rsp_code == 2'(m_rspc), "R2 rsp_code", rsp_code, m_rspc);
        chk(ovf_flag == m_ovf, "R3 ovf_flag", ovf_flag, m_ovf);
        chk(pcycle_flag == m_pc, "R6 pcycle_flag", pcycle_flag, m_pc);
        chk(abort_trap == (m_arb == 3), "R7 abort_trap", abort_trap, m_arb == 3);
        chk(retry_req == (m_arb == 2), "R8 retry_req", retry_req, m_arb == 2);
        chk(tx_active == (m_txs != 0), "R5 tx_active", tx_active, m_txs != 0);
        chk(tx_ts == TSW'(m_ts), "R10 tx_ts", tx_ts, m_ts);
    endtask

    task automatic clear_in();
        tx_begin = 0; tx_commit = 0; tx_abort = 0; abort_done = 0;
        acc_valid = 0; evict_valid = 0; fwd_valid = 0; own_nack = 0;
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare();
        clear_in();
    endtask

    task automatic access(int op, int idx, bit v, bit m);
        acc_valid = 1; acc_op = 2'(op); acc_idx = 3'(idx); acc_blk_valid = v; acc_blk_mod = m;
        step();
    endtask

    task automatic fwd(int kind, bit hit, int idx, int ts, int pid, int exp, string tag);
        fwd_valid = 1; fwd_kind = 2'(kind); fwd_hit = hit; fwd_idx = 3'(idx);
        fwd_ts = TSW'(ts); fwd_pid = PW'(pid);
        step();
        chk(rsp_code == 2'(exp), tag, rsp_code, exp);
    endtask

    task automatic nack_retry(int ts, int pid, int b, string tag);
        own_nack = 1; own_nack_ts = TSW'(ts); own_nack_pid = PW'(pid);
        step();
        chk(abort_trap == 0, tag, abort_trap, 0);
        for (int k = 1; k <= b; k++) begin
            step();
            chk(retry_req == (k == b), tag, retry_req, k == b);
        end
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_r[i] = 0; m_w[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk(rsp_valid == 0 && rsp_code == 0, "R11 rsp", rsp_code, 0);
        chk(retry_req == 0 && abort_trap == 0, "R11 arb", retry_req, 0);
        chk(tx_active == 0 && ovf_flag == 0 && pcycle_flag == 0, "R11 flags", tx_active, 0);
        chk(tx_ts == 0, "R11 tx_ts", tx_ts, 0);
        step();
        // R1: access outside a transaction leaves no mark
        access(0, 0, 1, 0);
        fwd(1, 1, 0, 1, 1, 1, "R1 idle load no mark");
        ts_now = 100; tx_begin = 1; step();
        chk(tx_ts == 100, "R10 ts captured", tx_ts, 100);
        access(0, 1, 1, 0);
        access(0, 2, 0, 0);
        access(1, 3, 1, 1);
        access(1, 4, 1, 0);
        fwd(0, 1, 1, 200, 1, 1, "R2 gets read-only");
        fwd(1, 1, 1, 200, 1, 2, "R2 getx on read");
        chk(pcycle_flag == 0, "R6 later requester", pcycle_flag, 0);
        fwd(0, 1, 3, 200, 1, 2, "R1 store mod sets W");
        fwd(1, 1, 2, 200, 1, 1, "R1 invalid load no R");
        fwd(2, 1, 4, 200, 1, 1, "R1 store non-mod no W");
        fwd(2, 1, 3, 200, 1, 2, "R2 inv on W");
        fwd(1, 1, 1, 100, 7, 2, "R6 tie higher pid");
        chk(pcycle_flag == 0, "R6 tie higher pid is later", pcycle_flag, 0);
        fwd(1, 1, 1, 100, 3, 2, "R6 tie lower pid");
        chk(pcycle_flag == 1, "R6 tie lower pid is earlier", pcycle_flag, 1);
        // R8 backoff doubling and ceiling (later refuser, so no trap: R7)
        nack_retry(300, 2, 1, "R8 bo1");
        nack_retry(300, 2, 2, "R8 bo2");
        nack_retry(300, 2, 4, "R8 bo4");
        nack_retry(300, 2, 8, "R8 bo8");
        nack_retry(300, 2, 8, "R8 ceiling");
        // R7 trap from earlier refuser with pcycle set
        own_nack = 1; own_nack_ts = 10; own_nack_pid = 1; step();
        chk(abort_trap == 1, "R7 trap pulse", abort_trap, 1);
        step();
        chk(abort_trap == 0 && tx_active == 1, "R7 aborting", abort_trap, 0);
        fwd(0, 0, 6, 50, 1, 3, "R4 miss no spill while aborting");
        abort_done = 1; step();
        chk(pcycle_flag == 0 && tx_active == 0, "R10 abort end clears", pcycle_flag, 0);
        ts_now = 500; tx_begin = 1; step();
        chk(tx_ts == 100, "R10 ts kept on restart", tx_ts, 100);
        fwd(1, 1, 1, 200, 1, 1, "R10 marks cleared by abort");
        tx_begin = 1; step();
        access(0, 5, 1, 0);
        evict_valid = 1; evict_idx = 6; step();
        chk(ovf_flag == 0, "R3 unmarked evict", ovf_flag, 0);
        evict_valid = 1; evict_idx = 5; step();
        chk(ovf_flag == 1, "R3 marked evict", ovf_flag, 1);
        fwd(0, 0, 5, 200, 1, 2, "R4 miss with spill");
        access(1, 3, 1, 1);
        tx_commit = 1; step();
        chk(ovf_flag == 1 && tx_active == 1, "R5 inner commit keeps", ovf_flag, 1);
        tx_commit = 1; step();
        chk(ovf_flag == 0 && tx_active == 0, "R5 outer commit clears", ovf_flag, 0);
        fwd(0, 0, 5, 200, 1, 3, "R4 miss idle clean");
        fwd(0, 1, 3, 200, 1, 1, "R5 W cleared");
        ts_now = 700; tx_begin = 1; step();
        chk(tx_ts == 700, "R10 fresh ts after commit", tx_ts, 700);
        access(2, 2, 1, 0);
        fwd(0, 1, 2, 800, 1, 2, "R9 sticky fill sets W");
        fwd(1, 0, 7, 800, 1, 3, "R4 miss active no spill");
        nack_retry(900, 2, 1, "R8 bo reset");
        nack_retry(10, 0, 2, "R7 earlier refuser without pcycle retries");
        tx_commit = 1; step();
        step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule